// File: doc/BRIEF.md
# Profile Modulation and Linear Sweep Controller

This block chooses, once per channel, the value that drives one tuning input (frequency, phase or amplitude) of a direct digital synthesis core. It has two uses. In level-select mode, a group of profile pins picks one of up to sixteen stored words, which gives multi-level frequency, phase or amplitude keying. In sweep mode, the same pins drive a ramp accumulator instead. The accumulator climbs by a rising step or falls by a falling step, and it clamps at programmed limits.

The profile pins are sampled only on a sync pulse that the block derives from the system clock by a fixed division. Between pulses the pins have no effect. A 3-bit pin configuration input picks the pin assignment. In level-select mode it also sets how many pins take part. Stored words are loaded through a plain write port into a memory that maps onto block RAM. Each ramp step is applied only after a programmable number of sync periods.

Top module: `profile_sweep_ctrl`

## Requirements
- R1: While `rst` is high, `tune_word` is 0 and `sync_pulse` is 0.
- R2: `sync_pulse` is high for exactly one clock in every SYNC_DIV (default 4) clocks.
- R3: The profile pins are sampled only at a clock edge where `sync_pulse` is high. In level-select mode, `tune_word` shows the selected word two clocks after that edge. A pin change between sync pulses has no effect until the next sampling edge.
- R4: Level-select mode is `pin_cfg[2]` = 0. `pin_cfg[1:0]` = n gives 2^(n+1) levels. The stored word at index (pins AND (2^(n+1)-1)) is selected.
- R5: In level-select mode with fewer than sixteen levels, the pin bits above the active ones are ignored.
- R6: Sweep mode is `pin_cfg[2]` = 1. Pin bit 0 = 1 ramps up by `rise_step`, and pin bit 0 = 0 ramps down by `fall_step`. Pin bits 3..1 are ignored. A step uses the pin value sampled at the previous sync pulse. A reversal sampled on a stepping edge therefore takes effect from the next step.
- R7: In sweep mode, a step is applied once every `ramp_rate`+1 sync pulses.
- R8: A rising ramp stops at `hi_limit` and holds there, with no wraparound.
- R9: A falling ramp stops at `lo_limit` and holds there, with no wraparound.
- R10: Outside sweep mode, the accumulator is held at `lo_limit`. On the first clock after sweep mode is entered, `tune_word` equals `lo_limit`.
- R11: The environment keeps a sampled pin change steady for at least two sync periods. This rule is checked at the next sampling edge.
- R12: A word written through the write port to the currently selected index appears on `tune_word` two clocks after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| profile_pins | input | PIN_W (4) | Profile pins: level code or ramp direction |
| pin_cfg | input | 3 | Pin assignment: bit 2 selects sweep, bits 1:0 select the level count |
| wr_en | input | 1 | Write strobe for the stored words |
| wr_idx | input | PIN_W (4) | Index of the word to write |
| wr_word | input | VAL_W (32) | Word to write |
| lo_limit | input | VAL_W (32) | Lower ramp limit and ramp start value |
| hi_limit | input | VAL_W (32) | Upper ramp limit |
| rise_step | input | VAL_W (32) | Increment per rising step |
| fall_step | input | VAL_W (32) | Decrement per falling step |
| ramp_rate | input | RATE_W (8) | Sync pulses per step, minus one |
| sync_pulse | output | 1 | Sync pulse marking each sampling edge |
| tune_word | output | VAL_W (32) | Selected value for the synthesis core |

## Verification
The collision that matters is a direction reversal sampled on the same edge where the rate counter fires a step. With `ramp_rate` = 0, every sync pulse steps. The bench flips pin 0 just after one sampling edge, with the upper pins set so that they must be ignored. The value after each following pulse is judged against a model in which the step on the reversal edge still follows the old direction and all later steps follow the new one. Clamping at both limits is checked on the same run.

// File: rtl/pmsw_pkg.sv
package pmsw_pkg;
  localparam int CFG_W = 3;

  typedef enum logic {
    RAMP_DOWN = 1'b0,
    RAMP_UP   = 1'b1
  } ramp_dir_e;

  function automatic logic cfg_is_sweep(input logic [CFG_W-1:0] cfg);
    return cfg[2];
  endfunction
endpackage

// File: rtl/pmsw_sync_gen.sv
module pmsw_sync_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PRE  = CW'(DIV - 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + CW'(1);
      tick <= (cnt == PRE);
    end
  end

  // R2: the pulse never lasts two clocks
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pmsw_profile_sel.sv
module pmsw_profile_sel #(
  parameter int W      = 32,
  parameter int LEVELS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic [$clog2(LEVELS)-1:0] pins,
  input  logic [1:0]                lvl_sel,
  input  logic                      wr_en,
  input  logic [$clog2(LEVELS)-1:0] wr_idx,
  input  logic [W-1:0]              wr_word,
  output logic [W-1:0]              sel_word,
  output logic                      dir_bit
);
  localparam int AW = $clog2(LEVELS);

  logic [W-1:0]  mem [LEVELS];
  logic [AW-1:0] pin_q;
  logic [AW-1:0] lvl_mask;
  logic [AW-1:0] rd_addr;
  logic          chg_last;

  // active pin bits: bit b takes part when b <= lvl_sel
  for (genvar b = 0; b < AW; b++) begin : g_mask
    assign lvl_mask[b] = (int'(lvl_sel) >= b);
  end

  assign rd_addr = pin_q & lvl_mask;
  assign dir_bit = pin_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= '0;
      chg_last <= 1'b0;
    end else if (tick) begin
      pin_q    <= pins;
      chg_last <= (pins != pin_q);
    end
  end

  // block-RAM style: write port plus registered read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
    sel_word <= mem[rd_addr];
  end

  // R3: sampled pins move only on a sync pulse
  assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pin_q));

  // R11: a sampled change is still present one sync period later
  assert_pin_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (tick && chg_last) |-> (pins == pin_q));
endmodule

// File: rtl/pmsw_ramp.sv
module pmsw_ramp
  import pmsw_pkg::*;
#(
  parameter int W      = 32,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  ramp_dir_e         dir,
  input  logic [W-1:0]      lo,
  input  logic [W-1:0]      hi,
  input  logic [W-1:0]      rise,
  input  logic [W-1:0]      fall,
  input  logic [RATE_W-1:0] rate,
  output logic [W-1:0]      acc
);
  logic [RATE_W-1:0] rc;
  logic [W:0]        sum_up;
  logic [W:0]        diff_dn;
  logic [W-1:0]      nxt_up;
  logic [W-1:0]      nxt_dn;
  logic              step;

  assign step    = en && tick && (rc >= rate);
  assign sum_up  = {1'b0, acc} + {1'b0, rise};
  assign diff_dn = {1'b0, acc} - {1'b0, fall};

  always_comb begin
    nxt_up = (sum_up >= {1'b0, hi}) ? hi : sum_up[W-1:0];
    nxt_dn = (diff_dn[W] || (diff_dn[W-1:0] <= lo)) ? lo : diff_dn[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      rc  <= '0;
    end else if (!en) begin
      acc <= lo;
      rc  <= '0;
    end else if (tick) begin
      if (rc >= rate) begin
        rc  <= '0;
        acc <= (dir == RAMP_UP) ? nxt_up : nxt_dn;
      end else begin
        rc <= rc + RATE_W'(1);
      end
    end
  end

  // R7: the accumulator moves only on a step
  assert_hold_between_steps_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(acc));

  // R8: a rising step never lands above the upper limit
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (step && dir == RAMP_UP) |=> (acc <= $past(hi)));

  // R9: a falling step never lands below the lower limit
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (step && dir == RAMP_DOWN) |=> (acc >= $past(lo)));

  // R10: outside sweep mode the accumulator rests at the lower limit
  assert_idle_at_lo_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc == $past(lo)));
endmodule

// File: rtl/profile_sweep_ctrl.sv
module profile_sweep_ctrl
  import pmsw_pkg::*;
#(
  parameter int VAL_W    = 32,
  parameter int LEVELS   = 16,
  parameter int SYNC_DIV = 4,
  parameter int RATE_W   = 8,
  localparam int PIN_W   = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  profile_pins,
  input  logic [CFG_W-1:0]  pin_cfg,
  input  logic              wr_en,
  input  logic [PIN_W-1:0]  wr_idx,
  input  logic [VAL_W-1:0]  wr_word,
  input  logic [VAL_W-1:0]  lo_limit,
  input  logic [VAL_W-1:0]  hi_limit,
  input  logic [VAL_W-1:0]  rise_step,
  input  logic [VAL_W-1:0]  fall_step,
  input  logic [RATE_W-1:0] ramp_rate,
  output logic              sync_pulse,
  output logic [VAL_W-1:0]  tune_word
);
  logic             tick;
  logic             sweep_on;
  logic             dir_bit;
  logic [VAL_W-1:0] sel_word;
  logic [VAL_W-1:0] acc;

  assign sweep_on   = cfg_is_sweep(pin_cfg);
  assign sync_pulse = tick;

  pmsw_sync_gen #(.DIV(SYNC_DIV)) u_sync (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  pmsw_profile_sel #(.W(VAL_W), .LEVELS(LEVELS)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pins    (profile_pins),
    .lvl_sel (pin_cfg[1:0]),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word (wr_word),
    .sel_word(sel_word),
    .dir_bit (dir_bit)
  );

  pmsw_ramp #(.W(VAL_W), .RATE_W(RATE_W)) u_ramp (
    .clk (clk),
    .rst (rst),
    .en  (sweep_on),
    .tick(tick),
    .dir (ramp_dir_e'(dir_bit)),
    .lo  (lo_limit),
    .hi  (hi_limit),
    .rise(rise_step),
    .fall(fall_step),
    .rate(ramp_rate),
    .acc (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) tune_word <= '0;
    else     tune_word <= sweep_on ? acc : sel_word;
  end

  // R1: the output leaves reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tune_word == '0));
endmodule

// File: tb/profile_sweep_ctrl_bench.sv
module profile_sweep_ctrl_bench;
  localparam int W  = 32;
  localparam int LV = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] profile_pins = '0;
  logic [2:0]    pin_cfg = 3'd3;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_word = '0;
  logic [W-1:0]  lo_limit = 32'd100;
  logic [W-1:0]  hi_limit = 32'd1000;
  logic [W-1:0]  rise_step = 32'd70;
  logic [W-1:0]  fall_step = 32'd33;
  logic [7:0]    ramp_rate = 8'd0;
  logic          sync_pulse;
  logic [W-1:0]  tune_word;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] words [LV];
  longint exp_v;
  logic cur_up, nxt_up;

  always #2 clk = ~clk;

  profile_sweep_ctrl u_profile_sweep_ctrl (
    .clk(clk), .rst(rst), .profile_pins(profile_pins), .pin_cfg(pin_cfg),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .lo_limit(lo_limit), .hi_limit(hi_limit), .rise_step(rise_step),
    .fall_step(fall_step), .ramp_rate(ramp_rate),
    .sync_pulse(sync_pulse), .tune_word(tune_word)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // returns just after a sampling edge (sync_pulse was high before it)
  task automatic wait_tick_edge();
    do @(negedge clk); while (!sync_pulse);
    @(posedge clk);
  endtask

  function automatic int sel_index(input logic [1:0] c, input logic [AW-1:0] p);
    logic [4:0] m;
    m = (5'd2 << c) - 5'd1;
    return int'(p & m[AW-1:0]);
  endfunction

  task automatic mod_step(input logic [1:0] c, input logic [AW-1:0] p, input string req);
    wait_tick_edge();
    @(negedge clk);
    pin_cfg = {1'b0, c};
    profile_pins = p;
    repeat (6) @(negedge clk);
    chk(req, tune_word, words[sel_index(c, p)]);
  endtask

  task automatic sweep_tick(input string req);
    wait_tick_edge();
    if (cur_up) exp_v = (exp_v + rise_step >= hi_limit) ? hi_limit : exp_v + rise_step;
    else        exp_v = (exp_v - fall_step <= lo_limit) ? lo_limit : exp_v - fall_step;
    cur_up = nxt_up;
    @(negedge clk);
    @(negedge clk);
    chk(req, tune_word, exp_v[W-1:0]);
  endtask

  task automatic enter_sweep();
    wait_tick_edge();
    @(negedge clk);
    pin_cfg = 3'd4;
    @(negedge clk);
    chk("R10 entry value", tune_word, lo_limit);
    exp_v = lo_limit;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int last_hi, prev_chg, seed_dummy;
    logic [W-1:0] prev;
    seed_dummy = $urandom(32'h5eed);
    // load words during reset (storage has no reset)
    for (int i = 0; i < LV; i++) begin
      @(negedge clk);
      words[i] = $urandom() ^ 32'(i);
      wr_en = 1'b1; wr_idx = AW'(i); wr_word = words[i];
      chk("R1 reset tune", tune_word, '0);
      chk("R1 reset pulse", {31'd0, sync_pulse}, '0);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b0;

    // R2: pulse period
    last_hi = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sync_pulse) begin
        if (last_hi >= 0) chk("R2 pulse spacing", 32'(k - last_hi), 32'd4);
        last_hi = k;
      end
    end

    // R4: full 16 levels, then R3 timing around a sampling edge
    mod_step(2'd3, 4'd5, "R4 sixteen levels");
    wait_tick_edge();
    @(negedge clk);
    profile_pins = 4'd9;
    repeat (5) @(negedge clk);
    chk("R3 change not yet sampled", tune_word, words[5]);
    @(negedge clk);
    chk("R3 change after sampling", tune_word, words[9]);

    // R5: upper bits ignored
    mod_step(2'd1, 4'b1110, "R5 four levels");
    mod_step(2'd0, 4'b1110, "R5 two levels");
    mod_step(2'd2, 4'b1011, "R5 eight levels");

    // random level selection
    for (int it = 0; it < 30; it++)
      mod_step(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), "R4 R5 random");

    // R12: write to the selected word
    mod_step(2'd3, 4'd7, "R4 select seven");
    @(negedge clk);
    words[7] = 32'hCAFE_0123;
    wr_en = 1'b1; wr_idx = 4'd7; wr_word = words[7];
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 written word shown", tune_word, words[7]);

    // sweep: pins up, rate 0, reversal collision, both clamps
    mod_step(2'd3, 4'd1, "R4 select one");
    repeat (2) wait_tick_edge();
    enter_sweep();
    cur_up = 1'b1; nxt_up = 1'b1;
    for (int t = 0; t < 8; t++) sweep_tick("R6 rising step");
    profile_pins = 4'b1110;   // down, upper bits set and ignored
    nxt_up = 1'b0;
    sweep_tick("R6 reversal on stepping edge keeps old direction");
    for (int t = 0; t < 23; t++) sweep_tick("R9 falling to lower clamp");
    chk("R9 held at lower limit", tune_word, lo_limit);
    profile_pins = 4'b0001;
    nxt_up = 1'b1;
    for (int t = 0; t < 16; t++) sweep_tick("R8 rising to upper clamp");
    chk("R8 held at upper limit", tune_word, hi_limit);

    // R7: step interval with rate 2 (three sync pulses per step)
    wait_tick_edge();
    @(negedge clk);
    pin_cfg = 3'd3;
    lo_limit = 32'd0; hi_limit = 32'd10000; rise_step = 32'd5; ramp_rate = 8'd2;
    repeat (8) @(negedge clk);
    enter_sweep();
    prev = tune_word;
    prev_chg = -1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (tune_word != prev) begin
        chk("R7 step size", tune_word - prev, 32'd5);
        if (prev_chg >= 0) chk("R7 step interval", 32'(k - prev_chg), 32'd12);
        prev_chg = k;
        prev = tune_word;
      end
    end
    chk("R7 steps seen", 32'(prev_chg > 0), 32'd1);

    summary();
    $finish;
  end
endmodule